// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block recovers words from a single asynchronous NRZ line. Each frame is one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. A one-cycle tick input arrives at sixteen times the bit rate. The line is re-timed into the clock domain and sampled on every tick. Each bit level is decided by a two-of-three vote over the samples taken on three consecutive ticks around the middle of the bit.

Finished words go into a two-entry queue. Each entry holds the data byte, the ninth bit and a framing-error bit, so the status of the word at the head always matches that word. The consumer drains the queue through a valid/ready pair. The head word is offered while `out_valid` is high and is removed on each clock edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the head word and its status stay on the outputs unchanged. The serial line cannot be stalled. If a word completes when both entries are occupied and no read happens in that cycle, the word is dropped and a sticky overrun flag is raised. While that flag is set, every later word is dropped. The flag is cleared only by taking `rx_enable` low, which also returns the frame logic to idle. Words already in the queue are kept and can still be read.

Top module: `rxm_uart_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and `overrun` is 0.
- R2: In 8-bit mode (`nine_bit_mode`=0), the eight bits after the start bit appear on `out_data`, with the first bit received in bit 0. `out_ninth` reads 0 for such a word.
- R3: In 9-bit mode (`nine_bit_mode`=1, sampled when the start edge is detected), the ninth bit received is stored with its word and is shown on `out_ninth`.
- R4: A start edge is a tick sample of 0 that follows a tick sample of 1. Bit levels are voted over the samples on ticks 7, 8 and 9 after that edge, and on the same three ticks of each later 16-tick bit period. One wrong sample out of the three does not change the bit.
- R5: If the start-bit vote reads high, the receiver returns to idle and no word is produced.
- R6: `out_ferr` is 1 for a word whose voted stop bit is low, and 0 when the stop bit is high.
- R7: The ninth bit and the framing-error bit are queued per word. After a read, both show the values of the next word.
- R8: The queue holds two words. A word is removed only on a cycle where `out_valid` and `out_ready` are both high. When `out_ready` is low, the outputs hold steady. `out_valid` is 0 when the queue is empty.
- R9: If a stop bit completes while both entries are full and no read happens in that cycle, `overrun` goes to 1 and the word is discarded. The queued words are unaffected.
- R10: While `overrun` is 1, no completed word enters the queue.
- R11: `overrun` clears only while `rx_enable` is 0. While `rx_enable` is 0, frames on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_enable | input | 1 | Receive enable; taking it low clears overrun and idles the frame logic |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame |
| out_ready | input | 1 | Consumer accepts the head word |
| out_valid | output | 1 | Queue holds at least one word |
| out_data | output | 8 | Data byte of the head word |
| out_ninth | output | 1 | Ninth bit of the head word |
| out_ferr | output | 1 | Framing-error bit of the head word |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The receiver is tried with clean 8-bit and 9-bit frames. These show that the bits are ordered correctly and that the ninth bit is captured only in 9-bit mode. A frame with a one-tick glitch inside a data bit's vote window separates a majority decision from a single-sample decision. A short low pulse on an idle line separates start validation from plain edge detection. Frames with a low stop bit, read back next to clean frames, show that the status bits move with their words. A run of frames sent without reading, continued after the queue fills and then followed by an enable toggle, separates discard-on-full, the blocking of later words and the clearing of the flag.

// File: rtl/rxm_pkg.sv
`timescale 1ns/1ps
package rxm_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic              ninth;
    logic [WORD_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/rxm_sampler.sv
`timescale 1ns/1ps
module rxm_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tick,
  output logic line_s,
  output logic prev_s,
  output logic vote
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;

  // re-time the line into the clock domain, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  assign line_s = sync_q[SYNC_STAGES-1];

  // keep the two previous tick samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= 2'b11;
    else if (tick) hist_q <= {hist_q[0], line_s};
  end

  assign prev_s = hist_q[0];
  // two-of-three over the previous two tick samples and the current one
  assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_s) | (hist_q[0] & line_s);
endmodule

// File: rtl/rxm_deframer.sv
`timescale 1ns/1ps
module rxm_deframer
  import rxm_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     nine_bit,
  input  logic     tick,
  input  logic     line_s,
  input  logic     prev_s,
  input  logic     vote,
  output logic     word_stb,
  output rx_word_t word
);
  localparam int CNT_W   = $clog2(OSR);
  localparam int MID_IDX = OSR / 2;
  localparam int LST_IDX = OSR - 1;
  localparam int IDX_W   = $clog2(WORD_W + 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W:0]  rsr_q;
  logic             nine_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = nine_q ? IDX_W'(WORD_W) : IDX_W'(WORD_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      rsr_q    <= '0;
      nine_q   <= 1'b0;
      word_stb <= 1'b0;
      word     <= '0;
    end else begin
      word_stb <= 1'b0;
      if (!enable) begin
        state_q <= ST_IDLE;
      end else if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            if (prev_s && !line_s) begin
              state_q <= ST_START;
              cnt_q   <= '0;
              rsr_q   <= '0;
              nine_q  <= nine_bit;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_W'(MID_IDX)) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= vote ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_W'(LST_IDX)) begin
              cnt_q        <= '0;
              rsr_q[idx_q] <= vote;
              if (idx_q == last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_W'(LST_IDX)) begin
              word_stb   <= 1'b1;
              word.data  <= rsr_q[WORD_W-1:0];
              word.ninth <= nine_q & rsr_q[WORD_W];
              word.ferr  <= ~vote;
              state_q    <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  bit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q <= last_idx));

  // R4
  strobe_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> ($past(state_q) == ST_STOP && $past(tick)));
endmodule

// File: rtl/rxm_fifo.sv
`timescale 1ns/1ps
module rxm_fifo
  import rxm_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t din,
  input  logic     pop,
  output rx_word_t dout,
  output logic     empty,
  output logic     full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));
  assign dout  = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q        <= step(wr_q);
      end
      if (pop) rd_q <= step(rd_q);
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  // R9
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R8
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxm_uart_rx.sv
`timescale 1ns/1ps
module rxm_uart_rx
  import rxm_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic              rx_enable,
  input  logic              nine_bit_mode,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_ninth,
  output logic              out_ferr,
  output logic              overrun
);
  logic     line_s, prev_s, vote;
  logic     word_stb;
  rx_word_t word, head;
  logic     empty, full, push, pop, overrun_q;

  rxm_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .tick(tick16),
    .line_s(line_s), .prev_s(prev_s), .vote(vote)
  );

  rxm_deframer #(.OSR(OSR)) u_deframer (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable), .nine_bit(nine_bit_mode),
    .tick(tick16), .line_s(line_s), .prev_s(prev_s), .vote(vote),
    .word_stb(word_stb), .word(word)
  );

  assign pop  = out_valid && out_ready;
  assign push = word_stb && !overrun_q && (!full || pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       overrun_q <= 1'b0;
    else if (!rx_enable)                              overrun_q <= 1'b0;
    else if (word_stb && !overrun_q && full && !pop)  overrun_q <= 1'b1;
  end

  rxm_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(word), .pop(pop),
    .dout(head), .empty(empty), .full(full)
  );

  assign out_valid = !empty;
  assign out_data  = head.data;
  assign out_ninth = head.ninth;
  assign out_ferr  = head.ferr;
  assign overrun   = overrun_q;

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_enable) |=> overrun);

  // R10
  no_fill_in_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !$rose(out_valid));

  // R11
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !overrun);

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr)));
endmodule

// File: tb/sim_rxm_uart_rx.sv
`timescale 1ns/1ps
module sim_rxm_uart_rx;
  localparam int BT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_enable = 1'b0;
  logic       nine_bit_mode = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_ninth, out_ferr, overrun;
  logic [7:0] out_data;
  logic [1:0] tdiv = '0;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  rxm_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .rx_enable(rx_enable), .nine_bit_mode(nine_bit_mode), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ninth(out_ninth),
    .out_ferr(out_ferr), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx_line = v;
    repeat (BT) @(negedge clk);
  endtask

  // glitch: one tick-wide inversion inside the vote window of data bit gbit
  task automatic send_frame(input logic [7:0] d, input logic n9, input logic nine,
                            input logic stop_v, input int gbit);
    @(negedge clk);
    send_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      logic v;
      v = (i == 8) ? n9 : d[i];
      if (i == gbit) begin
        rx_line = v;  repeat (32) @(negedge clk);
        rx_line = ~v; repeat (4) @(negedge clk);
        rx_line = v;  repeat (28) @(negedge clk);
      end else begin
        send_bit(v);
      end
    end
    send_bit(stop_v);
    rx_line = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic pop_word();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", {15'd0, out_valid}, 16'd0);
    chk("R1 overrun after reset", {15'd0, overrun}, 16'd0);
  endtask

  task automatic t_basic8();
    nine_bit_mode = 1'b0;
    send_frame(8'hA5, 1'b1, 1'b0, 1'b1, -1);
    chk("R2 valid", {15'd0, out_valid}, 16'd1);
    chk("R2 data", {8'd0, out_data}, 16'h00A5);
    chk("R2 ninth zero in 8-bit mode", {15'd0, out_ninth}, 16'd0);
    chk("R6 ferr clean", {15'd0, out_ferr}, 16'd0);
    repeat (20) @(negedge clk);
    chk("R8 held without ready", {7'd0, out_valid, out_data}, 16'h01A5);
    pop_word();
    chk("R8 empty after read", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_nine();
    nine_bit_mode = 1'b1;
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1, -1);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1, -1);
    chk("R3 data", {8'd0, out_data}, 16'h003C);
    chk("R3 ninth one", {15'd0, out_ninth}, 16'd1);
    pop_word();
    chk("R7 ninth follows head", {7'd0, out_ninth, out_data}, 16'h00C3);
    pop_word();
    nine_bit_mode = 1'b0;
  endtask

  task automatic t_majority();
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 3);
    chk("R4 one bad sample outvoted", {8'd0, out_data}, 16'h005A);
    pop_word();
    send_frame(8'h00, 1'b0, 1'b0, 1'b1, 0);
    chk("R4 bad sample on zero bit", {7'd0, out_valid, out_data}, 16'h0100);
    pop_word();
  endtask

  task automatic t_false_start();
    @(negedge clk);
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (11 * BT) @(negedge clk);
    chk("R5 no word from short low pulse", {15'd0, out_valid}, 16'd0);
    send_frame(8'h81, 1'b0, 1'b0, 1'b1, -1);
    chk("R5 receiver idle afterwards", {7'd0, out_valid, out_data}, 16'h0181);
    pop_word();
  endtask

  task automatic t_framing();
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, -1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1, -1);
    chk("R6 ferr on low stop", {7'd0, out_ferr, out_data}, 16'h0111);
    pop_word();
    chk("R7 ferr follows head", {7'd0, out_ferr, out_data}, 16'h0022);
    pop_word();
  endtask

  task automatic t_overrun();
    send_frame(8'h01, 1'b0, 1'b0, 1'b1, -1);
    send_frame(8'h02, 1'b0, 1'b0, 1'b1, -1);
    chk("R8 two words held", {7'd0, overrun, out_data}, 16'h0001);
    send_frame(8'h03, 1'b0, 1'b0, 1'b1, -1);
    chk("R9 overrun set", {15'd0, overrun}, 16'd1);
    chk("R9 head kept", {8'd0, out_data}, 16'h0001);
    pop_word();
    chk("R9 second word kept", {7'd0, out_valid, out_data}, 16'h0102);
    pop_word();
    send_frame(8'h04, 1'b0, 1'b0, 1'b1, -1);
    chk("R10 blocked while overrun", {15'd0, out_valid}, 16'd0);
    chk("R11 overrun stays set", {15'd0, overrun}, 16'd1);
    @(negedge clk);
    rx_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 overrun cleared by enable low", {15'd0, overrun}, 16'd0);
    rx_enable = 1'b1;
    send_frame(8'h05, 1'b0, 1'b0, 1'b1, -1);
    chk("R11 reception resumes", {7'd0, out_valid, out_data}, 16'h0105);
    pop_word();
  endtask

  task automatic t_disabled();
    rx_enable = 1'b0;
    send_frame(8'h77, 1'b0, 1'b0, 1'b1, -1);
    chk("R11 frame ignored when disabled", {15'd0, out_valid}, 16'd0);
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    rx_enable = 1'b1;
    repeat (5) @(negedge clk);
    t_basic8();
    t_nine();
    t_majority();
    t_false_start();
    t_framing();
    t_overrun();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule